// File: doc/BRIEF.md
# Byte FIFO with Hysteretic Request Alarm and Maskable Error Flags

This block is a byte-wide FIFO controller, 128 entries deep by default, with a first-word-fall-through read side. It tracks its own occupancy and shows two live flags: `fifo_empty` and a request alarm `alarm_req`. The alarm uses hysteresis. It goes high once occupancy reaches a programmed level. It goes low only when free space drops below a threshold set by a small granularity field. After that, it goes high again only when occupancy first falls below the level and then climbs back to it.

A simple register port gives access to two words. The control word holds the alarm level, the granularity, a frame-mark bit that is stored but has no effect, and one mask bit per error source. The status word holds six sticky event bits and reads back the two live flags. Sticky bits are cleared by writing one to them. Any sticky bit whose mask is clear drives the registered `err_irq` output.

Two of the six error sources come from inside the block: underflow (a pop while empty) and overflow (a push while full). The other four come from outside through `ext_evt`: bad pointer, frame reject, receive wait and transmit wait.

Top module: `fifo_alarm_ctrl`

## Requirements
- R1: While reset is asserted, the outputs and registers hold these values:
    - The control word reads 0x0024_1000: granularity 1, receive-wait mask set, transmit-wait mask set.
    - The status word reads 0x0000_0100: only the empty flag is set.
    - `fill_count` is 0, and `alarm_req` and `err_irq` are low.
- R2: Data leaves in the order it was written. `pop_data` always shows the oldest entry. `fill_count` tracks accepted pushes and pops. Status bit 8 and `fifo_empty` are high exactly when `fill_count` is 0.
- R3: A push while full sets sticky status bit 4 (overflow). The pushed byte is dropped, and neither occupancy nor the stored data changes.
- R4: A pop while empty sets sticky status bit 3 (underflow), and `fill_count` stays at 0.
- R5: When `alarm_req` is low and the alarm is armed, `alarm_req` rises one cycle after `fill_count` first reaches the level in control bits [11:0]. The alarm is armed out of reset.
- R6: Once high, `alarm_req` falls one cycle after free space (DEPTH minus `fill_count`) drops below the granularity (control bits [14:12]) times 4. It does not fall when occupancy drops below the level.
- R7: After it falls, the alarm stays low until occupancy has been below the level while the alarm is low, and then reaches the level again.
- R8: Suppose the granularity times 4 is greater than DEPTH minus the level. Then each time the alarm is raised, `alarm_req` is high for exactly one cycle.
- R9: `err_irq` is high one cycle after any sticky status bit is set while its mask bit (control bits [21:16], with the same bit order as the status bits) is clear. A masked source still sets its sticky bit but does not raise `err_irq`.
- R10: Writing the status word clears every sticky bit written as one. An event in the same cycle as its clear leaves that bit set.
- R11: Control bit 15 (frame mark) is stored and reads back, but has no effect on FIFO behaviour. Control bits [31:22] and status bits [31:10] and [7:6] read as zero.
- R12: `ext_evt` bits 0, 1, 2 and 3 set sticky status bits 0 (bad pointer), 1 (frame reject), 2 (receive wait) and 5 (transmit wait).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_en | input | 1 | Write one byte into the FIFO |
| push_data | input | 8 | Byte to write |
| pop_en | input | 1 | Remove the oldest byte |
| pop_data | output | 8 | Oldest byte currently stored |
| ext_evt | input | 4 | External error event pulses |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 selects the control word, 1 the status word |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected word |
| fill_count | output | 8 | Current occupancy, 0 to DEPTH |
| fifo_empty | output | 1 | Live empty flag |
| alarm_req | output | 1 | Hysteretic request alarm |
| err_irq | output | 1 | Registered OR of the unmasked sticky bits |

## Verification
The bench builds the block with its default parameters: depth 128, 8-bit data, a 12-bit level, a 3-bit granularity and a unit of 4 bytes. With a depth of 128, the bench can drive the FIFO to full and into overflow with a few hundred cycles of directed pushes. It can also drive free space below every granularity threshold. The 12-bit level allows a level near the depth, which makes the one-cycle alarm pulse reachable. The default masks let the bench compare masked and unmasked sources without reconfiguring first.

// File: rtl/fifo_alarm_pkg.sv
// Shared constants for the hysteretic-alarm FIFO controller.
// Holds the error source indices, the status word layout and the
// reset value of the mask field. Assumes six error sources.
package fifo_alarm_pkg;

    localparam int NUM_SRC = 6;
    localparam int NUM_EXT = 4;

    // Sticky status bit index of each error source
    localparam int SRC_BAD_PTR   = 0;
    localparam int SRC_FRAME_REJ = 1;
    localparam int SRC_RX_WAIT   = 2;
    localparam int SRC_UNDERFLOW = 3;
    localparam int SRC_OVERFLOW  = 4;
    localparam int SRC_TX_WAIT   = 5;

    // Mapping of ext_evt bits onto sticky indices
    localparam int EXT_MAP [NUM_EXT] = '{SRC_BAD_PTR, SRC_FRAME_REJ, SRC_RX_WAIT, SRC_TX_WAIT};

    // Status word positions of the live flags
    localparam int STAT_EMPTY_BIT = 8;
    localparam int STAT_ALARM_BIT = 9;

    // Receive-wait and transmit-wait masked out of reset
    localparam logic [NUM_SRC-1:0] MASK_RESET = 6'b100100;

    // Next value of a sticky set: new events win over clears
    function automatic logic [NUM_SRC-1:0] sticky_next(
        input logic [NUM_SRC-1:0] cur,
        input logic [NUM_SRC-1:0] set_v,
        input logic [NUM_SRC-1:0] clr_v
    );
        return set_v | (cur & ~clr_v);
    endfunction

endpackage

// File: rtl/fifo_byte_store.sv
// Storage, pointers and occupancy of the byte FIFO.
// Drops a push while full and a pop while empty, and flags each drop
// for one cycle. The read side shows the oldest entry without delay.
// Assumes DEPTH >= 2; any depth works, and power-of-two depths use a
// free-running pointer wrap.
module fifo_byte_store #(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  count,
    output logic              is_empty,
    output logic              is_full,
    output logic              push_drop,
    output logic              pop_drop
);

    localparam int  AW      = $clog2(DEPTH);
    localparam bit  POW2    = ((1 << AW) == DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [AW-1:0]     wr_ptr_inc, rd_ptr_inc;
    logic              push_ok, pop_ok;

    assign is_empty  = (count == '0);
    assign is_full   = (count == CNT_W'(DEPTH));
    assign push_ok   = push_req && !is_full;
    assign pop_ok    = pop_req && !is_empty;
    assign push_drop = push_req && is_full;
    assign pop_drop  = pop_req && is_empty;
    assign pop_data  = mem[rd_ptr];

    // Pointer increment: free wrap for power-of-two depth, compare otherwise
    generate
        if (POW2) begin : g_wrap_free
            assign wr_ptr_inc = wr_ptr + 1'b1;
            assign rd_ptr_inc = rd_ptr + 1'b1;
        end else begin : g_wrap_cmp
            assign wr_ptr_inc = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_ptr_inc = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    // Store accepted bytes
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Advance pointers on accepted accesses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr_inc;
            if (pop_ok)  rd_ptr <= rd_ptr_inc;
        end
    end

    // Track occupancy from accepted accesses only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/alarm_hysteresis.sv
// Request alarm with hysteresis on FIFO occupancy.
// Rises when armed and occupancy is at or above the level. Falls when
// free space is below gran*GRAN_UNIT. Re-arms only while low and below
// the level. It does not guard against a threshold larger than the
// headroom; that case gives a one-cycle pulse by design.
module alarm_hysteresis #(
    parameter int DEPTH     = 128,
    parameter int CNT_W     = $clog2(DEPTH + 1),
    parameter int LEVEL_W   = 12,
    parameter int GRAN_W    = 3,
    parameter int GRAN_UNIT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   count,
    input  logic [LEVEL_W-1:0] level,
    input  logic [GRAN_W-1:0]  gran,
    output logic               alarm
);

    logic        armed;
    logic        at_level;
    logic        low_room;
    logic [31:0] free_bytes;
    logic [31:0] thresh;

    assign free_bytes = 32'(DEPTH) - 32'(count);
    assign thresh     = 32'(gran) * 32'(GRAN_UNIT);
    assign at_level   = (32'(count) >= 32'(level));
    assign low_room   = (free_bytes < thresh);

    // Alarm state: rise on armed level crossing, fall on low free space
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm <= 1'b0;
        end else if (alarm) begin
            if (low_room) alarm <= 1'b0;
        end else if (armed && at_level) begin
            alarm <= 1'b1;
        end
    end

    // Arming: consumed on rise, restored while low and below the level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b1;
        end else if (!alarm && armed && at_level) begin
            armed <= 1'b0;
        end else if (!alarm && !at_level) begin
            armed <= 1'b1;
        end
    end

endmodule

// File: rtl/err_status.sv
// Sticky error bits with write-one-to-clear and a registered error output.
// Assumes event inputs are single-cycle pulses; a set wins over a clear
// in the same cycle.
module err_status
    import fifo_alarm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] event_in,
    input  logic               clr_we,
    input  logic [NUM_SRC-1:0] clr_bits,
    input  logic [NUM_SRC-1:0] mask,
    output logic [NUM_SRC-1:0] sticky,
    output logic               err
);

    logic [NUM_SRC-1:0] clr_eff;

    assign clr_eff = clr_bits & {NUM_SRC{clr_we}};

    // Record events and apply clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky <= '0;
        end else begin
            sticky <= sticky_next(sticky, event_in, clr_eff);
        end
    end

    // Register the OR of unmasked sticky bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else begin
            err <= |(sticky & ~mask);
        end
    end

endmodule

// File: rtl/fifo_alarm_ctrl.sv
// Top of the hysteretic-alarm byte FIFO controller.
// Holds the control word, builds the error event vector, and returns
// the control or status word on the register port. Assumes single-cycle
// register writes and at most one push and one pop per cycle.
module fifo_alarm_ctrl
    import fifo_alarm_pkg::*;
#(
    parameter int DEPTH      = 128,
    parameter int DATA_W     = 8,
    parameter int LEVEL_W    = 12,
    parameter int GRAN_W     = 3,
    parameter int GRAN_UNIT  = 4,
    parameter int GRAN_RESET = 1,
    parameter int REG_W      = 32,
    parameter int CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_en,
    output logic [DATA_W-1:0] pop_data,
    input  logic [NUM_EXT-1:0] ext_evt,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic [CNT_W-1:0]  fill_count,
    output logic              fifo_empty,
    output logic              alarm_req,
    output logic              err_irq
);

    localparam int GRAN_LSB  = LEVEL_W;
    localparam int FRAME_BIT = LEVEL_W + GRAN_W;
    localparam int MASK_LSB  = FRAME_BIT + 1;
    localparam int CTRL_W    = MASK_LSB + NUM_SRC;

    logic [LEVEL_W-1:0] level_q;
    logic [GRAN_W-1:0]  gran_q;
    logic               frame_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] sticky_q;
    logic [NUM_SRC-1:0] evt_vec;
    logic               full_w;
    logic               push_drop, pop_drop;
    logic               ctrl_we, stat_we;
    logic [REG_W-1:0]   ctrl_word, stat_word;
    logic               unused_wbits;

    assign ctrl_we      = cfg_we && !cfg_sel;
    assign stat_we      = cfg_we && cfg_sel;
    assign unused_wbits = ^{cfg_wdata[REG_W-1:CTRL_W], full_w};

    fifo_byte_store #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_en),
        .push_data (push_data),
        .pop_req   (pop_en),
        .pop_data  (pop_data),
        .count     (fill_count),
        .is_empty  (fifo_empty),
        .is_full   (full_w),
        .push_drop (push_drop),
        .pop_drop  (pop_drop)
    );

    alarm_hysteresis #(
        .DEPTH     (DEPTH),
        .CNT_W     (CNT_W),
        .LEVEL_W   (LEVEL_W),
        .GRAN_W    (GRAN_W),
        .GRAN_UNIT (GRAN_UNIT)
    ) u_alarm (
        .clk   (clk),
        .rst_n (rst_n),
        .count (fill_count),
        .level (level_q),
        .gran  (gran_q),
        .alarm (alarm_req)
    );

    // Route external pulses onto their sticky positions
    generate
        for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
            assign evt_vec[EXT_MAP[g]] = ext_evt[g];
        end
    endgenerate
    assign evt_vec[SRC_UNDERFLOW] = pop_drop;
    assign evt_vec[SRC_OVERFLOW]  = push_drop;

    err_status u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .event_in (evt_vec),
        .clr_we   (stat_we),
        .clr_bits (cfg_wdata[NUM_SRC-1:0]),
        .mask     (mask_q),
        .sticky   (sticky_q),
        .err      (err_irq)
    );

    // Control word register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            gran_q  <= GRAN_W'(GRAN_RESET);
            frame_q <= 1'b0;
            mask_q  <= MASK_RESET;
        end else if (ctrl_we) begin
            level_q <= cfg_wdata[LEVEL_W-1:0];
            gran_q  <= cfg_wdata[GRAN_LSB +: GRAN_W];
            frame_q <= cfg_wdata[FRAME_BIT];
            mask_q  <= cfg_wdata[MASK_LSB +: NUM_SRC];
        end
    end

    // Assemble readable words with reserved bits at zero
    always_comb begin
        ctrl_word = '0;
        ctrl_word[LEVEL_W-1:0]          = level_q;
        ctrl_word[GRAN_LSB +: GRAN_W]   = gran_q;
        ctrl_word[FRAME_BIT]            = frame_q;
        ctrl_word[MASK_LSB +: NUM_SRC]  = mask_q;
        stat_word = '0;
        stat_word[NUM_SRC-1:0]          = sticky_q;
        stat_word[STAT_EMPTY_BIT]       = fifo_empty;
        stat_word[STAT_ALARM_BIT]       = alarm_req;
    end

    // Read mux
    assign cfg_rdata = cfg_sel ? stat_word : ctrl_word;

endmodule

// File: rtl/fifo_alarm_ctrl_chk.sv
// Property checker for fifo_alarm_ctrl, attached with bind.
// Observes ports plus the sticky, mask and granularity state.
module fifo_alarm_ctrl_chk
    import fifo_alarm_pkg::*;
#(
    parameter int DEPTH     = 128,
    parameter int CNT_W     = $clog2(DEPTH + 1),
    parameter int GRAN_W    = 3,
    parameter int GRAN_UNIT = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               push_en,
    input logic               pop_en,
    input logic [CNT_W-1:0]   fill_count,
    input logic               alarm_req,
    input logic               err_irq,
    input logic [NUM_SRC-1:0] sticky,
    input logic [NUM_SRC-1:0] mask,
    input logic [GRAN_W-1:0]  gran
);

    logic [31:0] free_b, thr_b;
    assign free_b = 32'(DEPTH) - 32'(fill_count);
    assign thr_b  = 32'(gran) * 32'(GRAN_UNIT);

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        32'(fill_count) <= 32'(DEPTH));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && !pop_en && 32'(fill_count) == 32'(DEPTH))
        |=> (32'(fill_count) == 32'(DEPTH) && sticky[SRC_OVERFLOW]));

    assert_underflow_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && !push_en && fill_count == '0)
        |=> (fill_count == '0 && sticky[SRC_UNDERFLOW]));

    assert_alarm_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_req && free_b < thr_b) |=> !alarm_req);

    assert_alarm_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_req && free_b >= thr_b) |=> alarm_req);

    assert_err_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sticky & ~mask)) |=> err_irq);

    assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(sticky & ~mask)) |=> !err_irq);

endmodule

bind fifo_alarm_ctrl fifo_alarm_ctrl_chk #(
    .DEPTH     (DEPTH),
    .CNT_W     (CNT_W),
    .GRAN_W    (GRAN_W),
    .GRAN_UNIT (GRAN_UNIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_en    (push_en),
    .pop_en     (pop_en),
    .fill_count (fill_count),
    .alarm_req  (alarm_req),
    .err_irq    (err_irq),
    .sticky     (sticky_q),
    .mask       (mask_q),
    .gran       (gran_q)
);

// File: tb/fifo_alarm_ctrl_bench.sv
// Directed bench for fifo_alarm_ctrl: one task per scenario.
// Inputs change at the falling edge and outputs are sampled there.
module fifo_alarm_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        push_en, pop_en, cfg_we, cfg_sel;
    logic [7:0]  push_data, pop_data;
    logic [3:0]  ext_evt;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic [7:0]  fill_count;
    logic        fifo_empty, alarm_req, err_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fifo_alarm_ctrl u_fifo_alarm_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_en    (push_en),
        .push_data  (push_data),
        .pop_en     (pop_en),
        .pop_data   (pop_data),
        .ext_evt    (ext_evt),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .fill_count (fill_count),
        .fifo_empty (fifo_empty),
        .alarm_req  (alarm_req),
        .err_irq    (err_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic read_word(input logic sel, output logic [31:0] val);
        cfg_sel = sel;
        #1;
        val = cfg_rdata;
        cfg_sel = 1'b1;
    endtask

    task automatic cfg_write(input logic sel, input logic [31:0] val);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        tick();
        cfg_we = 1'b0; cfg_sel = 1'b1; cfg_wdata = '0;
    endtask

    task automatic push_byte(input logic [7:0] d);
        push_en = 1'b1; push_data = d;
        tick();
        push_en = 1'b0;
    endtask

    task automatic pop_byte();
        pop_en = 1'b1;
        tick();
        pop_en = 1'b0;
    endtask

    task automatic push_n(input int n);
        for (int i = 0; i < n; i++) push_byte(8'(i));
    endtask

    task automatic pop_n(input int n);
        for (int i = 0; i < n; i++) pop_byte();
    endtask

    task automatic pulse_ext(input logic [3:0] v);
        ext_evt = v;
        tick();
        ext_evt = '0;
    endtask

    function automatic logic [31:0] ctrl_val(input int lvl, input int gr, input bit fr, input logic [5:0] m);
        return 32'(lvl) | (32'(gr) << 12) | (32'(fr) << 15) | (32'(m) << 16);
    endfunction

    // R1: values held under reset; then R5 with level 0 after release
    task automatic t_reset();
        logic [31:0] v;
        rst_n = 1'b0; push_en = 0; pop_en = 0; cfg_we = 0; cfg_sel = 1;
        cfg_wdata = '0; push_data = '0; ext_evt = '0;
        repeat (3) tick();
        read_word(1'b0, v); chk("R1 ctrl reset", v, 32'h0024_1000);
        read_word(1'b1, v); chk("R1 status reset", v, 32'h0000_0100);
        chk("R1 count", 32'(fill_count), 0);
        chk("R1 alarm", 32'(alarm_req), 0);
        chk("R1 err", 32'(err_irq), 0);
        rst_n = 1'b1;
        tick();
        chk("R5 level 0 rises after reset", 32'(alarm_req), 1);
    endtask

    // R11: reserved bits read zero, frame mark stored
    task automatic t_ctrl_fields();
        logic [31:0] v;
        cfg_write(1'b0, 32'hFFFF_FFFF);
        read_word(1'b0, v); chk("R11 reserved ctrl bits zero", v, 32'h003F_FFFF);
        cfg_write(1'b0, ctrl_val(64, 1, 1'b1, 6'h24));
        read_word(1'b0, v); chk("R11 frame mark readback", v, 32'h0024_9040);
        read_word(1'b1, v); chk("R11 status reserved zero", v & 32'hFFFF_FCC0, 0);
    endtask

    // R2: ordering and empty flag, with frame mark set (R11 no effect)
    task automatic t_order();
        logic [31:0] v;
        push_byte(8'hA5); push_byte(8'h3C); push_byte(8'hF0);
        chk("R2 count 3", 32'(fill_count), 3);
        chk("R2 head A5", 32'(pop_data), 32'hA5);
        read_word(1'b1, v); chk("R2 empty bit low", 32'(v[8]), 0);
        pop_byte();
        chk("R2 head 3C", 32'(pop_data), 32'h3C);
        chk("R2 count 2", 32'(fill_count), 2);
        pop_byte();
        chk("R11 head F0 with frame mark", 32'(pop_data), 32'hF0);
        pop_byte();
        chk("R2 count 0", 32'(fill_count), 0);
        chk("R2 empty port", 32'(fifo_empty), 1);
        read_word(1'b1, v); chk("R2 empty bit high", 32'(v[8]), 1);
    endtask

    // R5, R6, R7: hysteresis with level 64, granularity 1
    task automatic t_hysteresis();
        push_n(124); tick();
        chk("R6 free 4 keeps alarm", 32'(alarm_req), 1);
        push_byte(8'h00);
        chk("R6 lag one cycle", 32'(alarm_req), 1);
        tick();
        chk("R6 free 3 drops alarm", 32'(alarm_req), 0);
        pop_n(125); tick();
        chk("R7 low after drain", 32'(alarm_req), 0);
        push_n(63); tick();
        chk("R5 below level", 32'(alarm_req), 0);
        push_byte(8'h00);
        chk("R5 same cycle still low", 32'(alarm_req), 0);
        tick();
        chk("R5 rises at level", 32'(alarm_req), 1);
        pop_n(54); tick();
        chk("R6 stays high below level", 32'(alarm_req), 1);
        push_n(115); tick();
        chk("R6 falls at free 3 again", 32'(alarm_req), 0);
        pop_n(25); tick();
        chk("R7 no rise above level", 32'(alarm_req), 0);
        pop_n(37); tick();
        chk("R7 low at 63", 32'(alarm_req), 0);
        push_byte(8'h00); tick();
        chk("R7 re-rises at level", 32'(alarm_req), 1);
    endtask

    // R8: level 120, granularity 4 gives a one-cycle pulse
    task automatic t_pulse();
        cfg_write(1'b0, ctrl_val(120, 4, 1'b0, 6'h24));
        push_n(49); tick();
        chk("R8 release at free 15", 32'(alarm_req), 0);
        push_n(7);
        chk("R8 count 120", 32'(fill_count), 120);
        chk("R8 not yet", 32'(alarm_req), 0);
        tick();
        chk("R8 pulse high", 32'(alarm_req), 1);
        tick();
        chk("R8 pulse ends", 32'(alarm_req), 0);
        tick();
        chk("R8 stays low", 32'(alarm_req), 0);
        pop_n(120);
    endtask

    // R4, R9, R10: underflow, error latency, clears
    task automatic t_underflow();
        logic [31:0] v;
        pop_byte();
        chk("R4 count stays 0", 32'(fill_count), 0);
        read_word(1'b1, v); chk("R4 underflow bit", v & 32'h3F, 32'h08);
        chk("R9 err not yet", 32'(err_irq), 0);
        tick();
        chk("R9 err one cycle later", 32'(err_irq), 1);
        cfg_write(1'b1, 32'h08);
        read_word(1'b1, v); chk("R10 cleared", v & 32'h3F, 0);
        chk("R9 err lags clear", 32'(err_irq), 1);
        tick();
        chk("R9 err drops", 32'(err_irq), 0);
        pop_en = 1'b1; cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 32'h08;
        tick();
        pop_en = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
        read_word(1'b1, v); chk("R10 event beats clear", v & 32'h3F, 32'h08);
        cfg_write(1'b1, 32'h3F);
        tick(); tick();
        chk("R10 err quiet after clear", 32'(err_irq), 0);
    endtask

    // R3: overflow drops the byte
    task automatic t_overflow();
        logic [31:0] v;
        push_n(128);
        chk("R3 full count", 32'(fill_count), 128);
        push_byte(8'h77);
        chk("R3 count unchanged", 32'(fill_count), 128);
        read_word(1'b1, v); chk("R3 overflow bit", v & 32'h3F, 32'h10);
        chk("R3 head unchanged", 32'(pop_data), 0);
        pop_n(127);
        chk("R3 last byte kept", 32'(pop_data), 127);
        pop_byte();
        chk("R3 drained", 32'(fill_count), 0);
        cfg_write(1'b1, 32'h3F);
        tick(); tick();
    endtask

    // R9, R12: external sources and masking
    task automatic t_ext_mask();
        logic [31:0] v;
        pulse_ext(4'b0100);
        read_word(1'b1, v); chk("R12 rx wait bit 2", v & 32'h3F, 32'h04);
        pulse_ext(4'b1000);
        read_word(1'b1, v); chk("R12 tx wait bit 5", v & 32'h3F, 32'h24);
        tick();
        chk("R9 masked sources quiet", 32'(err_irq), 0);
        pulse_ext(4'b0010);
        read_word(1'b1, v); chk("R12 frame reject bit 1", v & 32'h3F, 32'h26);
        tick();
        chk("R9 unmasked source raises err", 32'(err_irq), 1);
        cfg_write(1'b1, 32'h3F);
        tick(); tick();
        cfg_write(1'b0, ctrl_val(120, 4, 1'b0, 6'h2C));
        pop_byte(); tick(); tick();
        read_word(1'b1, v); chk("R9 masked underflow recorded", v & 32'h3F, 32'h08);
        chk("R9 masked underflow quiet", 32'(err_irq), 0);
        pulse_ext(4'b0001);
        read_word(1'b1, v); chk("R12 bad pointer bit 0", v & 32'h3F, 32'h09);
        tick();
        chk("R9 bad pointer raises err", 32'(err_irq), 1);
    endtask

    initial begin
        t_reset();
        t_ctrl_fields();
        t_order();
        t_hysteresis();
        t_pulse();
        t_underflow();
        t_overflow();
        t_ext_mask();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule